// File: doc/BRIEF.md
# I2C Transaction List Sequencer

This block runs an ordered list of I2C transactions against a byte-level I2C master engine. The host writes up to eight descriptors while the block is idle. Each descriptor holds a direction, a 7-bit target address, a byte count and an offset into a shared 64-byte data buffer. The host then pulses `go` together with the number of entries. For each transaction, the sequencer commands the engine to send a start and the address. It then moves one byte per engine data event: outgoing bytes are read from the buffer and incoming bytes are written into it. Consecutive transactions are chained with repeated starts, and only the final one asks the engine to stop on its own once its count is reached.

Control is a table-driven state machine with seven states. Events that need no input (leaving the fault, bus-error and NACK states) are resolved in the same clock as the event that led into them. Any event that the current state does not define lands in a fault state, which reports an error and then winds down through the stopping state. Every run ends with a one-cycle `done` pulse, and `done_err` shows whether a bus error or fault occurred.

The engine must leave at least one idle cycle between a command or consumed event and the next event. This gives the registered buffer read time to present the next outgoing byte.

Top module: `i2c_txn_seq`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `done`, `cmd_start`, `cmd_stop` and `tx_valid` are all 0.
- R2: `go` is accepted only while idle and with `cfg_count` not 0. One cycle after acceptance, `cmd_start` pulses with the address, length and direction of entry 0 and `busy` rises. A `go` while busy, or with a count of 0, causes no command.
- R3: `cmd_autoend` is 1 on the start command of the last listed transaction and 0 on every other start command.
- R4: In a write transaction, each engine transmit request that arrives while bytes remain gives a `tx_valid` pulse in the next cycle. `tx_data` carries the buffer bytes from the descriptor offset upward, in order.
- R5: In a read transaction, each receive-ready event that arrives while bytes remain stores `ev_rxdata` at the descriptor offset plus the byte index. The host can read it back through `host_raddr`/`host_rdata`, with one cycle of read latency.
- R6: A transfer-complete event after the final byte of a transaction that is not the last gives a new `cmd_start` in the next cycle, carrying the next descriptor's fields (a repeated start).
- R7: Data events that arrive after the final byte of the last transaction are ignored: no `tx_valid` and no buffer write.
- R8: A stop-detect event during a transfer ends the run. `done` pulses for one cycle, two cycles after the event is sampled, with `done_err` = 0, and `busy` falls in that same cycle.
- R9: A NACK during address setup makes `cmd_stop` pulse in the next cycle and `done` pulse in the cycle after that. A NACK during data transfer ends the run without a `cmd_stop`. In both cases `done_err` is 0.
- R10: An error event other than NACK, during setup or transfer, ends the run with `done_err` = 1 and no `cmd_stop`.
- R11: An event that the setup state does not define (transfer-complete or stop-detect) drives the machine to the fault state, and the run ends with `done_err` = 1.
- R12: When several engine events arrive in the same cycle, the order of precedence is NACK, then other error, then data (transmit request or receive-ready), then transfer-complete, then stop-detect.
- R13: Engine events that arrive while the block is idle have no effect: no command, no data and no `done`.
- R14: The error status is cleared when a new `go` is accepted, so a clean run after a failed one reports `done_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe (taken only while idle) |
| cfg_idx | input | 3 | Descriptor index |
| cfg_read | input | 1 | Descriptor direction, 1 = read |
| cfg_addr | input | 7 | Descriptor target address |
| cfg_len | input | 8 | Descriptor byte count, 1 to 255 |
| cfg_off | input | 6 | Descriptor buffer offset |
| cfg_count | input | 4 | Number of listed transactions, sampled on `go` |
| host_wr | input | 1 | Buffer write strobe (taken only while idle) |
| host_waddr | input | 6 | Buffer write address |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | 6 | Buffer read address |
| host_rdata | output | 8 | Buffer read data, one cycle after the address |
| go | input | 1 | Start the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| done_err | output | 1 | Error status, valid with `done` |
| cmd_start | output | 1 | Start-and-address command pulse to the engine |
| cmd_addr | output | 7 | Target address of the command |
| cmd_len | output | 8 | Byte count of the command |
| cmd_read | output | 1 | Direction of the command, 1 = read |
| cmd_autoend | output | 1 | Engine stops by itself after the count |
| cmd_stop | output | 1 | Stop command pulse |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| ev_txreq | input | 1 | Engine requests the next outgoing byte |
| ev_rxrdy | input | 1 | Engine holds a received byte |
| ev_rxdata | input | 8 | Received byte |
| ev_tc | input | 1 | Transfer complete (count reached, soft end) |
| ev_stopdet | input | 1 | Stop condition detected |
| ev_nack | input | 1 | Not-acknowledge received |
| ev_err | input | 1 | Bus error, arbitration loss or overrun |

## Verification
The bench goes after the edges of a transaction. These include the surplus data event after the final byte, which a design without a remaining-byte guard would turn into an extra `tx_valid` or a stray buffer write. They also include the hand-over between transactions, where a wrong index step gives a repeated start with the wrong descriptor or auto-end on a transaction that is not the last. A NACK is sent in both setup and transfer, so that a design which confuses the two shows up as a missing or extra `cmd_start`/`cmd_stop` pulse. Events that arrive together, undefined events during setup, and a clean run right after a failed one expose a wrong precedence order, a missing fault path, or an error flag that sticks across runs.

// File: rtl/i2c_txn_seq_pkg.sv
package i2c_txn_seq_pkg;

  // Fault must stay at code zero: it is the landing place of every undefined pair.
  typedef enum logic [2:0] {
    ST_FAULT    = 3'd0,
    ST_BUSERR   = 3'd1,
    ST_IDLE     = 3'd2,
    ST_STOPPING = 3'd3,
    ST_SETUP    = 3'd4,
    ST_XFER     = 3'd5,
    ST_NACKED   = 3'd6
  } seq_state_t;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_BUSERR = 3'd1,
    EV_GO     = 3'd2,
    EV_BYTE   = 3'd3,
    EV_NEXT   = 3'd4,
    EV_NACK   = 3'd5,
    EV_STOP   = 3'd6
  } seq_event_t;

  function automatic seq_state_t next_on(seq_state_t s, seq_event_t e);
    seq_state_t r;
    r = ST_FAULT;
    case (s)
      ST_IDLE: begin
        if (e == EV_GO)          r = ST_SETUP;
        else if (e == EV_BUSERR) r = ST_BUSERR;
      end
      ST_STOPPING: begin
        if (e == EV_STOP)        r = ST_IDLE;
        else if (e == EV_BUSERR) r = ST_BUSERR;
      end
      ST_SETUP: begin
        if (e == EV_BYTE)        r = ST_XFER;
        else if (e == EV_NACK)   r = ST_NACKED;
        else if (e == EV_BUSERR) r = ST_BUSERR;
      end
      ST_XFER: begin
        if (e == EV_BYTE)                       r = ST_XFER;
        else if (e == EV_NEXT)                  r = ST_SETUP;
        else if (e == EV_NACK || e == EV_STOP)  r = ST_STOPPING;
        else if (e == EV_BUSERR)                r = ST_BUSERR;
      end
      default: r = ST_FAULT;
    endcase
    return r;
  endfunction

  // States left without waiting for any input
  function automatic logic has_auto(seq_state_t s);
    return (s == ST_FAULT) || (s == ST_BUSERR) || (s == ST_NACKED);
  endfunction

endpackage

// File: rtl/i2c_txn_seq_desc.sv
module i2c_txn_seq_desc #(
  parameter int N_TXN = 8,
  parameter int IW    = 3,
  parameter int AW    = 6,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic             w_read,
  input  logic [6:0]       w_addr,
  input  logic [LEN_W-1:0] w_len,
  input  logic [AW-1:0]    w_off,
  input  logic [IW-1:0]    ridx,
  output logic             r_read,
  output logic [6:0]       r_addr,
  output logic [LEN_W-1:0] r_len,
  output logic [AW-1:0]    r_off
);

  logic             dir_q [N_TXN];
  logic [6:0]       adr_q [N_TXN];
  logic [LEN_W-1:0] len_q [N_TXN];
  logic [AW-1:0]    off_q [N_TXN];

  for (genvar g = 0; g < N_TXN; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && widx == IW'(g)) begin
        dir_q[g] <= w_read;
        adr_q[g] <= w_addr;
        len_q[g] <= w_len;
        off_q[g] <= w_off;
      end
    end
  end

  assign r_read = dir_q[ridx];
  assign r_addr = adr_q[ridx];
  assign r_len  = len_q[ridx];
  assign r_off  = off_q[ridx];

endmodule

// File: rtl/i2c_txn_seq_buf.sv
module i2c_txn_seq_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] a_addr,
  output logic [7:0]    a_q,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_q
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/i2c_txn_seq_evdec.sv
module i2c_txn_seq_evdec
  import i2c_txn_seq_pkg::*;
(
  input  logic       txreq,
  input  logic       rxrdy,
  input  logic       tc,
  input  logic       stopdet,
  input  logic       nack,
  input  logic       err,
  input  logic       bytes_left,
  output seq_event_t ev
);

  always_comb begin
    if (nack)                               ev = EV_NACK;
    else if (err)                           ev = EV_BUSERR;
    else if ((txreq || rxrdy) && bytes_left) ev = EV_BYTE;
    else if (tc)                            ev = EV_NEXT;
    else if (stopdet)                       ev = EV_STOP;
    else                                    ev = EV_NONE;
  end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_txn_seq_pkg::*;
#(
  parameter int N_TXN     = 8,
  parameter int BUF_DEPTH = 64,
  parameter int LEN_W     = 8,
  localparam int IW = $clog2(N_TXN),
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(N_TXN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic             cfg_read,
  input  logic [6:0]       cfg_addr,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [AW-1:0]    cfg_off,
  input  logic [CW-1:0]    cfg_count,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_waddr,
  input  logic [7:0]       host_wdata,
  input  logic [AW-1:0]    host_raddr,
  output logic [7:0]       host_rdata,
  input  logic             go,
  output logic             busy,
  output logic             done,
  output logic             done_err,
  output logic             cmd_start,
  output logic [6:0]       cmd_addr,
  output logic [LEN_W-1:0] cmd_len,
  output logic             cmd_read,
  output logic             cmd_autoend,
  output logic             cmd_stop,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             ev_txreq,
  input  logic             ev_rxrdy,
  input  logic [7:0]       ev_rxdata,
  input  logic             ev_tc,
  input  logic             ev_stopdet,
  input  logic             ev_nack,
  input  logic             ev_err
);

  seq_state_t       state_q, s1, s2;
  seq_event_t       dec_ev, ev_sel;
  logic [IW-1:0]    cur_q, last_q, rd_idx, setup_last;
  logic [LEN_W-1:0] left_q;
  logic [AW-1:0]    ptr_q;
  logic             err_q;

  logic             d_read;
  logic [6:0]       d_addr;
  logic [LEN_W-1:0] d_len;
  logic [AW-1:0]    d_off;
  logic [7:0]       buf_a_q;
  logic             idle, take, seq_we, buf_we;
  logic [AW-1:0]    buf_waddr;
  logic [7:0]       buf_wdata;

  assign idle       = (state_q == ST_IDLE);
  assign rd_idx     = idle ? '0 : cur_q;
  assign setup_last = idle ? IW'(cfg_count - CW'(1)) : last_q;

  i2c_txn_seq_desc #(.N_TXN(N_TXN), .IW(IW), .AW(AW), .LEN_W(LEN_W)) u_desc (
    .clk(clk), .we(cfg_we && idle), .widx(cfg_idx), .w_read(cfg_read),
    .w_addr(cfg_addr), .w_len(cfg_len), .w_off(cfg_off), .ridx(rd_idx),
    .r_read(d_read), .r_addr(d_addr), .r_len(d_len), .r_off(d_off)
  );

  i2c_txn_seq_evdec u_evdec (
    .txreq(ev_txreq), .rxrdy(ev_rxrdy), .tc(ev_tc), .stopdet(ev_stopdet),
    .nack(ev_nack), .err(ev_err), .bytes_left(left_q != '0), .ev(dec_ev)
  );

  // Engine events count only while a transaction is on the bus.
  always_comb begin
    ev_sel = EV_NONE;
    if (idle) begin
      if (go && cfg_count != '0) ev_sel = EV_GO;
    end else if (state_q == ST_SETUP || state_q == ST_XFER) begin
      ev_sel = dec_ev;
    end
  end

  assign take = (ev_sel != EV_NONE);

  // One event plus any eventless follow-on resolved in a single clock
  always_comb begin
    s1 = state_q;
    if (take) s1 = next_on(state_q, ev_sel);
    s2 = has_auto(s1) ? ST_STOPPING : s1;
    if (state_q == ST_STOPPING) s2 = ST_IDLE;
  end

  assign seq_we    = take && (s1 == ST_XFER) && d_read;
  assign buf_we    = seq_we || (host_wr && idle);
  assign buf_waddr = seq_we ? ptr_q : host_waddr;
  assign buf_wdata = seq_we ? ev_rxdata : host_wdata;

  i2c_txn_seq_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .a_addr(ptr_q), .a_q(buf_a_q), .b_addr(host_raddr), .b_q(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      last_q      <= '0;
      left_q      <= '0;
      ptr_q       <= '0;
      err_q       <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      done_err    <= 1'b0;
      cmd_start   <= 1'b0;
      cmd_addr    <= '0;
      cmd_len     <= '0;
      cmd_read    <= 1'b0;
      cmd_autoend <= 1'b0;
      cmd_stop    <= 1'b0;
      tx_data     <= '0;
      tx_valid    <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      cmd_stop  <= 1'b0;
      tx_valid  <= 1'b0;
      done      <= 1'b0;
      state_q   <= s2;
      busy      <= (s2 != ST_IDLE);
      if (state_q == ST_STOPPING) begin
        done     <= 1'b1;
        done_err <= err_q;
      end
      if (take) begin
        case (s1)
          ST_FAULT, ST_BUSERR: err_q <= 1'b1;
          ST_NACKED:           cmd_stop <= 1'b1;
          ST_SETUP: begin
            if (idle) begin
              cur_q  <= '0;
              last_q <= setup_last;
              err_q  <= 1'b0;
            end
            cmd_start   <= 1'b1;
            cmd_addr    <= d_addr;
            cmd_len     <= d_len;
            cmd_read    <= d_read;
            cmd_autoend <= (rd_idx == setup_last);
            ptr_q       <= d_off;
            left_q      <= d_len;
          end
          ST_XFER: begin
            if (!d_read) begin
              tx_data  <= buf_a_q;
              tx_valid <= 1'b1;
            end
            ptr_q  <= ptr_q + AW'(1);
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1) && cur_q != last_q) cur_q <= cur_q + IW'(1);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic [CW-1:0] cfg_count,
  input logic          busy,
  input logic          done,
  input logic          done_err,
  input logic          cmd_start,
  input logic          cmd_stop,
  input logic          tx_valid
);

  assert_go_starts_R2: assert property (@(posedge clk) disable iff (rst)
    (go && !busy && cfg_count != '0) |=> (cmd_start && busy));

  assert_one_action_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_start, cmd_stop, tx_valid, done}));

  assert_tx_in_run_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_stop_then_done_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> (done && !done_err));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (!tx_valid && !cmd_stop && !done));

endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .go(go), .cfg_count(cfg_count), .busy(busy),
  .done(done), .done_err(done_err), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .tx_valid(tx_valid)
);

// File: tb/i2c_txn_seq_bench.sv
module i2c_txn_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_TXN = 8;
  localparam int BUF_DEPTH = 64;
  localparam int LEN_W = 8;
  localparam int IW = $clog2(N_TXN);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(N_TXN + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_read = 0, host_wr = 0, go = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [6:0] cfg_addr = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [AW-1:0] cfg_off = '0, host_waddr = '0, host_raddr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [7:0] host_wdata = '0, host_rdata, ev_rxdata = '0;
  logic ev_txreq = 0, ev_rxrdy = 0, ev_tc = 0, ev_stopdet = 0, ev_nack = 0, ev_err = 0;
  logic busy, done, done_err, cmd_start, cmd_read, cmd_autoend, cmd_stop, tx_valid;
  logic [6:0] cmd_addr;
  logic [LEN_W-1:0] cmd_len;
  logic [7:0] tx_data;

  int tests = 0, fails = 0;
  int mem_m [BUF_DEPTH];
  int t_rd [N_TXN], t_addr [N_TXN], t_len [N_TXN], t_off [N_TXN];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_txn_seq u_i2c_txn_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_read(cfg_read),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_off(cfg_off), .cfg_count(cfg_count),
    .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata), .go(go), .busy(busy),
    .done(done), .done_err(done_err), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_read(cmd_read), .cmd_autoend(cmd_autoend),
    .cmd_stop(cmd_stop), .tx_data(tx_data), .tx_valid(tx_valid),
    .ev_txreq(ev_txreq), .ev_rxrdy(ev_rxrdy), .ev_rxdata(ev_rxdata), .ev_tc(ev_tc),
    .ev_stopdet(ev_stopdet), .ev_nack(ev_nack), .ev_err(ev_err)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_txn(input int i, input int rd, input int a, input int len, input int off);
    t_rd[i] = rd; t_addr[i] = a; t_len[i] = len; t_off[i] = off;
    cfg_we = 1; cfg_idx = IW'(i); cfg_read = rd[0]; cfg_addr = 7'(a);
    cfg_len = LEN_W'(len); cfg_off = AW'(off);
    tick();
    cfg_we = 0;
  endtask

  task automatic fill(input int a, input int d);
    host_wr = 1; host_waddr = AW'(a); host_wdata = 8'(d);
    tick();
    host_wr = 0;
    mem_m[a] = d;
  endtask

  task automatic pulse(input bit txr, input bit rxr, input int rxd, input bit tc,
                       input bit sd, input bit nk, input bit er);
    ev_txreq = txr; ev_rxrdy = rxr; ev_rxdata = 8'(rxd);
    ev_tc = tc; ev_stopdet = sd; ev_nack = nk; ev_err = er;
    tick();
    ev_txreq = 0; ev_rxrdy = 0; ev_tc = 0; ev_stopdet = 0; ev_nack = 0; ev_err = 0;
  endtask

  task automatic launch(input int n);
    cfg_count = CW'(n); go = 1;
    tick();
    go = 0;
  endtask

  task automatic wait_start(input string tag);
    bit got;
    got = 0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (cmd_start) got = 1;
      else tick();
    end
    chk(got, tag, int'(got), 1);
  endtask

  task automatic end_and_check(input int exp_err, input string tag);
    tick();
    chk(done == 1'b1, tag, int'(done), 1);
    chk(done_err == exp_err[0], tag, int'(done_err), exp_err);
  endtask

  // Random list run; the engine is modelled here.
  task automatic run_list(input string err_tag);
    int n, off, d, lo;
    n = 1 + int'($urandom % 4);
    off = 0;
    for (int i = 0; i < n; i++) begin
      set_txn(i, int'($urandom % 2), int'($urandom % 128), 1 + int'($urandom % 6), off);
      off += t_len[i];
    end
    for (int a = 0; a < 32; a++) fill(a, int'($urandom % 256));
    launch(n);
    for (int t = 0; t < n; t++) begin
      wait_start(t == 0 ? "R2 first start" : "R6 repeated start");
      chk(int'(cmd_addr) == t_addr[t], "R6 cmd_addr", int'(cmd_addr), t_addr[t]);
      chk(int'(cmd_len) == t_len[t], "R6 cmd_len", int'(cmd_len), t_len[t]);
      chk(int'(cmd_read) == t_rd[t], "R6 cmd_read", int'(cmd_read), t_rd[t]);
      chk(cmd_autoend == (t == n - 1), "R3 autoend", int'(cmd_autoend), int'(t == n - 1));
      for (int b = 0; b < t_len[t]; b++) begin
        tick();
        if (t_rd[t] != 0) begin
          d = int'($urandom % 256);
          pulse(0, 1, d, 0, 0, 0, 0);
          mem_m[t_off[t] + b] = d;
          chk(tx_valid == 1'b0, "R5 no tx on read", int'(tx_valid), 0);
        end else begin
          pulse(1, 0, 0, 0, 0, 0, 0);
          chk(tx_valid == 1'b1, "R4 tx_valid", int'(tx_valid), 1);
          chk(int'(tx_data) == mem_m[t_off[t] + b], "R4 tx_data", int'(tx_data),
              mem_m[t_off[t] + b]);
        end
      end
      tick();
      if (t < n - 1) pulse(0, 0, 0, 1, 0, 0, 0);
    end
    // surplus data on the final transaction
    pulse(1, 1, 8'hA5, 0, 0, 0, 0);
    chk(tx_valid == 1'b0, "R7 surplus tx", int'(tx_valid), 0);
    tick();
    pulse(0, 0, 0, 0, 1, 0, 0);
    chk(done == 1'b0, "R8 done timing", int'(done), 0);
    end_and_check(0, err_tag);
    chk(busy == 1'b0, "R8 busy falls", int'(busy), 0);
    lo = t_off[n - 1] + t_len[n - 1];
    host_raddr = AW'(lo);
    tick();
    chk(int'(host_rdata) == mem_m[lo], "R7 no surplus write", int'(host_rdata), mem_m[lo]);
    for (int t = 0; t < n; t++) begin
      if (t_rd[t] != 0) begin
        for (int b = 0; b < t_len[t]; b++) begin
          host_raddr = AW'(t_off[t] + b);
          tick();
          chk(int'(host_rdata) == mem_m[t_off[t] + b], "R5 readback", int'(host_rdata),
              mem_m[t_off[t] + b]);
        end
      end
    end
  endtask

  task automatic one_write(input int len);
    set_txn(0, 0, 7'h2A, len, 40);
    launch(1);
    wait_start("R2 directed start");
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst = 0;
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(cmd_start == 1'b0 && cmd_stop == 1'b0, "R1 cmds", int'(cmd_start), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
    for (int a = 0; a < BUF_DEPTH; a++) fill(a, a);

    // R13: events while idle
    pulse(1, 1, 3, 1, 1, 1, 1);
    chk(busy == 1'b0 && cmd_start == 1'b0, "R13 idle busy", int'(busy), 0);
    chk(cmd_stop == 1'b0 && tx_valid == 1'b0, "R13 idle outputs", int'(tx_valid), 0);
    tick();
    chk(done == 1'b0, "R13 idle done", int'(done), 0);

    // R2: zero count ignored
    launch(0);
    chk(busy == 1'b0 && cmd_start == 1'b0, "R2 zero count", int'(busy), 0);

    // Random runs
    for (int r = 0; r < 6; r++) run_list("R8 clean end");

    // R9: NACK during setup
    set_txn(0, 1, 7'h11, 2, 50);
    launch(1);
    wait_start("R2 directed start");
    tick();
    pulse(0, 0, 0, 0, 0, 1, 0);
    chk(cmd_stop == 1'b1, "R9 stop on setup nack", int'(cmd_stop), 1);
    end_and_check(0, "R9 setup nack end");

    // R9: NACK during transfer
    one_write(3);
    pulse(1, 0, 0, 0, 0, 0, 0);
    tick();
    pulse(0, 0, 0, 0, 0, 1, 0);
    chk(cmd_stop == 1'b0, "R9 no stop on xfer nack", int'(cmd_stop), 0);
    end_and_check(0, "R9 xfer nack end");

    // R2: go while busy, then R10/R12: error together with data
    one_write(2);
    go = 1; cfg_count = 1;
    tick();
    go = 0;
    chk(cmd_start == 1'b0 && busy == 1'b1, "R2 go while busy", int'(cmd_start), 0);
    tick();
    pulse(1, 0, 0, 0, 0, 0, 1);
    chk(tx_valid == 1'b0, "R12 error beats data", int'(tx_valid), 0);
    chk(cmd_stop == 1'b0, "R10 no stop", int'(cmd_stop), 0);
    end_and_check(1, "R10 error end");
    run_list("R14 cleared error");

    // R11: undefined events during setup
    one_write(2);
    pulse(0, 0, 0, 1, 0, 0, 0);
    end_and_check(1, "R11 tc in setup");
    one_write(2);
    pulse(0, 0, 0, 0, 1, 0, 0);
    end_and_check(1, "R11 stop in setup");

    // R12: NACK beats other error and data
    one_write(2);
    pulse(1, 0, 0, 1, 0, 1, 1);
    chk(cmd_stop == 1'b1, "R12 nack first", int'(cmd_stop), 1);
    end_and_check(0, "R12 nack end");
    run_list("R14 cleared error");

    summary();
    $finish;
  end

endmodule